// File: doc/BRIEF.md
# Integrator Zero and Test-Pulse Self-Test Sequencer

Between beam events, this block checks that a toroid integrator channel is still healthy. Once the logic that handles the beam event reports it has finished, the sequencer asks the integrator for a sample with no beam present. The magnitude of that sample must not exceed a small drift limit. The sequencer then requests a calibration current pulse through the toroid. The magnitude of the resulting sample must fall inside a window close to full scale. This catches gain drift and broken cables.

A failed zero check, a failed window check, or a sample that never arrives each latch a separate trip flag. Any latched trip removes the output permit until the next reset. The permit is also held off for as long as an external calibration is running. The raw zero and test-pulse samples stay in registers so that the system around the block can read them.

Top module: `integ_selftest`

## Requirements
- R1: While `rst` is high and on the first clock edge after it: all trip flags are 0, both triggers are 0, `zero_val` and `test_val` are 0, `st_busy` is 0 and `permit` is 0. With no trip and no calibration, `permit` is 1 one cycle after reset is released.
- R2: An `event_done` pulse sampled while the sequencer is idle starts a run. `zero_trig` is high for exactly one cycle, starting on that edge. `st_busy` stays high from then until the run ends. An `event_done` seen while a run is in progress is ignored and does not produce a second zero trigger.
- R3: The zero sample is the `data_in` value (two's complement, `DATA_W` bits) present with `data_vld` while the run waits for it. `trip_zero` sets when the sample's magnitude exceeds `ZERO_LIM` (default 16). A magnitude equal to the limit passes. The most negative code is treated as magnitude 2^(DATA_W-1)-1.
- R4: On the edge that accepts the zero sample, `pulse_trig` goes high for exactly one cycle. This holds whether or not the zero check passed.
- R5: `trip_pulse` sets when the test-pulse sample's magnitude falls outside `WIN_LO`..`WIN_HI` (defaults 28000 and 32000, both ends inclusive). The sign of the sample does not matter.
- R6: `zero_val` and `test_val` hold the raw samples accepted in their wait states and change on no other edge. A `data_vld` that arrives while no sample is awaited leaves both registers unchanged.
- R7: If no `data_vld` arrives within `TMO_CYC` cycles (default 150) of a trigger, `trip_tmo` sets and the run ends. A zero-sample timeout produces no `pulse_trig`.
- R8: Every trip flag stays set until reset. `permit` is 0 from the cycle after any trip flag sets.
- R9: While `cal_busy` is high, `permit` is 0 from the next cycle on. It returns to 1 one cycle after `cal_busy` falls, provided no trip is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the trips |
| event_done | input | 1 | Pulse: beam event processing has finished |
| data_in | input | DATA_W | Integrator sample, two's complement |
| data_vld | input | 1 | Strobe: `data_in` is valid |
| cal_busy | input | 1 | External calibration is in progress |
| zero_trig | output | 1 | Request for a no-beam integrator sample |
| pulse_trig | output | 1 | Request for a calibration current pulse |
| zero_val | output | DATA_W | Last accepted zero sample |
| test_val | output | DATA_W | Last accepted test-pulse sample |
| trip_zero | output | 1 | Zero drift limit exceeded (sticky) |
| trip_pulse | output | 1 | Test pulse outside the window (sticky) |
| trip_tmo | output | 1 | Sample did not arrive in time (sticky) |
| st_busy | output | 1 | Self-test run in progress |
| permit | output | 1 | Output permit, active high |

## Verification
The hardest cases to reach from the ports are those about what does not happen: a run that times out and so never requests the test pulse, and a second `event_done` arriving in the middle of a run. To reach the first, the stimulus starts a run and then withholds `data_vld` on purpose. It samples `trip_tmo` well before and well after the 150-cycle window, and counts `pulse_trig` pulses at every falling clock edge. To reach the second, the stimulus pulses `event_done` while the run waits for the zero sample, finishes the run normally, and confirms that the trigger counter advanced by exactly one. Stray strobes during idle are driven with distinctive data, so that any leak into the sample registers would show up.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ZERO_TRIG  = 3'd1,
    ST_ZERO_WAIT  = 3'd2,
    ST_PULSE_TRIG = 3'd3,
    ST_PULSE_WAIT = 3'd4,
    ST_DONE       = 3'd5
  } st_state_e;

  typedef struct packed {
    logic zero;
    logic pulse;
    logic tmo;
  } st_trips_t;

endpackage

// File: rtl/st_magnitude.sv
module st_magnitude #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] val,
  output logic        [W-1:0] mag
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (val == MIN_NEG)
      mag = MAX_POS;
    else if (val[W-1])
      mag = W'(-val);
    else
      mag = val;
  end
endmodule

// File: rtl/st_limit_check.sv
module st_limit_check #(
  parameter int W  = 16,
  parameter int LO = 0,
  parameter int HI = 16
) (
  input  logic [W-1:0] mag,
  output logic         fail
);
  localparam logic [W-1:0] HI_V = W'(HI);

  generate
    if (LO == 0) begin : g_ceiling
      assign fail = (mag > HI_V);
    end else begin : g_window
      localparam logic [W-1:0] LO_V = W'(LO);
      assign fail = (mag < LO_V) || (mag > HI_V);
    end
  endgenerate
endmodule

// File: rtl/st_seq_fsm.sv
module st_seq_fsm
  import selftest_pkg::*;
#(
  parameter int TMO_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic vld,
  output logic zero_trig,
  output logic pulse_trig,
  output logic zero_take,
  output logic pulse_take,
  output logic tmo_hit,
  output logic busy
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);

  st_state_e state, state_n;
  logic [CW-1:0] cnt;
  logic waiting;

  assign waiting    = (state == ST_ZERO_WAIT) || (state == ST_PULSE_WAIT);
  assign zero_trig  = (state == ST_ZERO_TRIG);
  assign pulse_trig = (state == ST_PULSE_TRIG);
  assign busy       = (state != ST_IDLE);
  assign zero_take  = (state == ST_ZERO_WAIT)  && vld;
  assign pulse_take = (state == ST_PULSE_WAIT) && vld;
  assign tmo_hit    = waiting && !vld && (cnt == CNT_LAST);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:       if (start) state_n = ST_ZERO_TRIG;
      ST_ZERO_TRIG:  state_n = ST_ZERO_WAIT;
      ST_ZERO_WAIT:  if (vld) state_n = ST_PULSE_TRIG;
                     else if (tmo_hit) state_n = ST_DONE;
      ST_PULSE_TRIG: state_n = ST_PULSE_WAIT;
      ST_PULSE_WAIT: if (vld || tmo_hit) state_n = ST_DONE;
      ST_DONE:       state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      if (waiting && cnt != CNT_LAST) cnt <= cnt + 1'b1;
      else if (!waiting)              cnt <= '0;
    end
  end

  // R2: each zero request lasts a single cycle
  a_r2_zero_trig_single: assert property (@(posedge clk) disable iff (rst)
    zero_trig |=> !zero_trig);

  // R4: accepting the zero sample leads straight to the pulse request
  a_r4_pulse_follows_zero: assert property (@(posedge clk) disable iff (rst)
    zero_take |=> pulse_trig);

  // R7: a zero-sample timeout never requests the test pulse
  a_r7_tmo_skips_pulse: assert property (@(posedge clk) disable iff (rst)
    (tmo_hit && state == ST_ZERO_WAIT) |=> (!pulse_trig && state == ST_DONE));
endmodule

// File: rtl/integ_selftest.sv
module integ_selftest
  import selftest_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ZERO_LIM = 16,
  parameter int WIN_LO   = 28000,
  parameter int WIN_HI   = 32000,
  parameter int TMO_CYC  = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_vld,
  input  logic              cal_busy,
  output logic              zero_trig,
  output logic              pulse_trig,
  output logic [DATA_W-1:0] zero_val,
  output logic [DATA_W-1:0] test_val,
  output logic              trip_zero,
  output logic              trip_pulse,
  output logic              trip_tmo,
  output logic              st_busy,
  output logic              permit
);
  logic [DATA_W-1:0] mag;
  logic zero_fail, win_fail;
  logic zero_take, pulse_take, tmo_hit;
  st_trips_t trips;

  st_magnitude #(.W(DATA_W)) u_mag (
    .val (data_in),
    .mag (mag)
  );

  st_limit_check #(.W(DATA_W), .LO(0), .HI(ZERO_LIM)) u_zero_chk (
    .mag  (mag),
    .fail (zero_fail)
  );

  st_limit_check #(.W(DATA_W), .LO(WIN_LO), .HI(WIN_HI)) u_win_chk (
    .mag  (mag),
    .fail (win_fail)
  );

  st_seq_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (event_done),
    .vld        (data_vld),
    .zero_trig  (zero_trig),
    .pulse_trig (pulse_trig),
    .zero_take  (zero_take),
    .pulse_take (pulse_take),
    .tmo_hit    (tmo_hit),
    .busy       (st_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_val <= '0;
      test_val <= '0;
      trips    <= '0;
      permit   <= 1'b0;
    end else begin
      if (zero_take) begin
        zero_val <= data_in;
        if (zero_fail) trips.zero <= 1'b1;
      end
      if (pulse_take) begin
        test_val <= data_in;
        if (win_fail) trips.pulse <= 1'b1;
      end
      if (tmo_hit) trips.tmo <= 1'b1;
      permit <= (trips == '0) && !cal_busy;
    end
  end

  assign trip_zero  = trips.zero;
  assign trip_pulse = trips.pulse;
  assign trip_tmo   = trips.tmo;

  // R1: reset clears permit and trips
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!permit && !trip_zero && !trip_pulse && !trip_tmo));

  // R8: trips are sticky
  a_r8_trip_sticky: assert property (@(posedge clk) disable iff (rst)
    (trip_zero || trip_pulse || trip_tmo) |=>
      ($past(trip_zero) <= trip_zero && $past(trip_pulse) <= trip_pulse
       && $past(trip_tmo) <= trip_tmo));

  // R8: any trip removes the permit
  a_r8_trip_kills_permit: assert property (@(posedge clk) disable iff (rst)
    (trip_zero || trip_pulse || trip_tmo) |=> !permit);

  // R9: calibration in progress removes the permit
  a_r9_cal_kills_permit: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> !permit);

  // R6: sample registers move only on an accepted sample
  a_r6_zero_hold: assert property (@(posedge clk) disable iff (rst)
    !zero_take |=> $stable(zero_val));
endmodule

// File: tb/tb_integ_selftest.sv
module tb_integ_selftest;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic event_done = 1'b0;
  logic [W-1:0] data_in = '0;
  logic data_vld = 1'b0;
  logic cal_busy = 1'b0;
  logic zero_trig, pulse_trig, trip_zero, trip_pulse, trip_tmo, st_busy, permit;
  logic [W-1:0] zero_val, test_val;

  int n_chk = 0;
  int n_err = 0;
  int zt_cnt = 0;
  int pt_cnt = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  integ_selftest dut (
    .clk(clk), .rst(rst), .event_done(event_done), .data_in(data_in),
    .data_vld(data_vld), .cal_busy(cal_busy), .zero_trig(zero_trig),
    .pulse_trig(pulse_trig), .zero_val(zero_val), .test_val(test_val),
    .trip_zero(trip_zero), .trip_pulse(trip_pulse), .trip_tmo(trip_tmo),
    .st_busy(st_busy), .permit(permit)
  );

  always @(negedge clk) begin
    if (zero_trig)  zt_cnt++;
    if (pulse_trig) pt_cnt++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; event_done = 1'b0; data_vld = 1'b0; cal_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // full run: zero sample z, test sample t; inputs change at falling edges
  task automatic run_seq(input logic signed [W-1:0] z, input logic signed [W-1:0] t);
    event_done = 1'b1;
    @(negedge clk); event_done = 1'b0;
    chk("R2", "zero_trig after start", int'(zero_trig), 1);
    @(negedge clk);
    data_in = z; data_vld = 1'b1;
    @(negedge clk); data_vld = 1'b0;
    chk("R4", "pulse_trig after zero sample", int'(pulse_trig), 1);
    chk("R6", "zero_val captured", int'($signed(zero_val)), int'(z));
    @(negedge clk);
    data_in = t; data_vld = 1'b1;
    @(negedge clk); data_vld = 1'b0;
    chk("R6", "test_val captured", int'($signed(test_val)), int'(t));
    @(negedge clk); @(negedge clk);
    chk("R2", "busy cleared after run", int'(st_busy), 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "permit in reset", int'(permit), 0);
    chk("R1", "trips in reset", int'({trip_zero, trip_pulse, trip_tmo}), 0);
    chk("R1", "triggers in reset", int'({zero_trig, pulse_trig}), 0);
    chk("R1", "values in reset", int'({zero_val, test_val}), 0);
    chk("R1", "busy in reset", int'(st_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "permit after reset", int'(permit), 1);
  endtask

  task automatic t_pass_bounds();
    do_reset();
    run_seq(16'sd16, 16'sd28000);
    run_seq(-16'sd16, 16'sd32000);
    run_seq(16'sd0, -16'sd30000);
    chk("R3", "zero at limit passes", int'(trip_zero), 0);
    chk("R5", "window edges pass", int'(trip_pulse), 0);
    chk("R8", "permit with no trip", int'(permit), 1);
  endtask

  task automatic t_zero_fail();
    do_reset();
    run_seq(16'sd17, 16'sd30000);
    chk("R3", "zero 17 trips", int'(trip_zero), 1);
    chk("R5", "good pulse no trip", int'(trip_pulse), 0);
    chk("R8", "permit after trip", int'(permit), 0);
    run_seq(16'sd0, 16'sd30000);
    chk("R8", "zero trip sticky", int'(trip_zero), 1);
    do_reset();
    run_seq(16'sh8000, 16'sd30000);
    chk("R3", "most negative zero trips", int'(trip_zero), 1);
  endtask

  task automatic t_window_fail();
    do_reset();
    run_seq(16'sd0, 16'sd27999);
    chk("R5", "below window trips", int'(trip_pulse), 1);
    chk("R3", "clean zero no trip", int'(trip_zero), 0);
    do_reset();
    run_seq(16'sd0, 16'sd32001);
    chk("R5", "above window trips", int'(trip_pulse), 1);
    do_reset();
    run_seq(16'sd0, 16'sh8000);
    chk("R5", "most negative pulse trips", int'(trip_pulse), 1);
  endtask

  task automatic t_timeout();
    int pt0;
    do_reset();
    pt0 = pt_cnt;
    event_done = 1'b1;
    @(negedge clk); event_done = 1'b0;
    for (int i = 0; i < 140; i++) @(negedge clk);
    chk("R7", "no timeout before window", int'(trip_tmo), 0);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk("R7", "timeout trip set", int'(trip_tmo), 1);
    chk("R7", "no pulse after zero timeout", pt_cnt - pt0, 0);
    chk("R7", "run ended", int'(st_busy), 0);
    chk("R8", "permit off on timeout", int'(permit), 0);
  endtask

  task automatic t_stray_vld();
    do_reset();
    run_seq(16'sd5, 16'sd29000);
    data_in = 16'h1234; data_vld = 1'b1;
    @(negedge clk); @(negedge clk);
    data_vld = 1'b0;
    @(negedge clk);
    chk("R6", "zero_val kept on stray strobe", int'($signed(zero_val)), 5);
    chk("R6", "test_val kept on stray strobe", int'($signed(test_val)), 29000);
    chk("R6", "no trips from stray strobe", int'({trip_zero, trip_pulse, trip_tmo}), 0);
  endtask

  task automatic t_busy_ignore();
    int zt0;
    do_reset();
    zt0 = zt_cnt;
    event_done = 1'b1;
    @(negedge clk); event_done = 1'b0;
    @(negedge clk);
    event_done = 1'b1;
    @(negedge clk); event_done = 1'b0;
    data_in = 16'sd3; data_vld = 1'b1;
    @(negedge clk); data_vld = 1'b0;
    @(negedge clk);
    data_in = 16'sd30000; data_vld = 1'b1;
    @(negedge clk); data_vld = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R2", "restart while busy ignored", zt_cnt - zt0, 1);
    chk("R2", "idle after run", int'(st_busy), 0);
  endtask

  task automatic t_cal();
    do_reset();
    cal_busy = 1'b1;
    @(negedge clk);
    chk("R9", "permit off during calibration", int'(permit), 0);
    @(negedge clk);
    chk("R9", "permit stays off", int'(permit), 0);
    cal_busy = 1'b0;
    @(negedge clk);
    chk("R9", "permit back after calibration", int'(permit), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_pass_bounds();
    t_zero_fail();
    t_window_fail();
    t_timeout();
    t_stray_vld();
    t_busy_ignore();
    t_cal();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule